// File: doc/BRIEF.md
# MAC Header Field Rewriter

This block sits in the transmit path for 802.11 frames that software hands over already framed, in raw or native-wifi form. The header bytes travel through it on a byte-wide valid/ready stream with no added latency. A 64-bit setup word is taken in with each frame. For each rewritable header field, that word carries a protect bit and a replacement setting. Where a field's protect bit is clear, the block writes the replacement into that field as the byte goes past. Where the bit is set, the byte is forwarded as it arrived.

The fields it can rewrite are the eight flag bits of the second frame-control byte, the duration, the sequence control, and the QoS control. Some settings take three values. They pick a constant 0, a constant 1, or a value that comes from a side input: the retry bitmap bit, or the crypto-enabled flag. Sequence control can come from the MPDU-start sequence number or from fields held inside the setup word. The setup word and all side inputs are captured on the start-of-frame byte and held for the rest of the frame. A setting code that is not defined leaves its bit untouched and sets a sticky error flag.

Top module: `mac_hdr_rewriter`

## Requirements
- R1: The stream passes straight through in the same cycle: outValid equals inValid, inReady equals outReady, and outSof equals inSof. Byte index 0 is the inSof byte. Bytes 0, 4..21 and 26 onward are always forwarded unchanged. When qosPresent was low at start of frame, bytes 24..25 are also forwarded unchanged.
- R2: Setup bits 0..13 and 15 are protect bits for the following fields, in this order: to-DS, from-DS, more-frag, retry, pwr-mgt, more-data, protected, order, duration, sequence control, TID, EOSP, ack policy, A-MSDU, and QoS bits 15..8. A protect bit of 1 leaves its field exactly as it arrived.
- R3: Byte 1 holds the frame-control flags at b0 to-DS, b1 from-DS, b2 more-frag, b3 retry, b4 pwr-mgt, b5 more-data, b6 protected, b7 order. When a flag is unprotected, to-DS is written from setup bit 17, from-DS from bit 18, more-frag from bit 19, pwr-mgt from bit 22, and order from bit 27.
- R4: The retry code is setup bits 21:20. Code 0 writes 0, code 1 writes 1, and code 2 writes the retryBit input.
- R5: The more-data code is setup bits 24:23. Code 0 writes 0, code 1 writes 1, and code 2 writes 0.
- R6: The protected code is setup bits 26:25. Code 0 writes 0, code 1 writes 1, and code 2 writes the cryptoOn input.
- R7: When duration is unprotected, bytes 2 (low) and 3 (high) are replaced by durVal.
- R8: When sequence control is unprotected, bytes 22 (low) and 23 (high) are replaced. Setup bit 47 picks the source. With bit 47 at 0 the value is {mpduSeq, 4'h0}. With bit 47 at 1 it is {setup[63:52], setup[51:48]}.
- R9: When qosPresent is high, byte 24 takes TID (setup 31:28) in bits 3:0, ack policy (setup 35:34) in bits 6:5, and A-MSDU (setup 36) in bit 7. Byte 25 takes setup 44:37. Each part is written only when its own protect bit is clear.
- R10: The EOSP code is setup bits 33:32 and goes to byte 24 bit 4. Code 0 writes 0, code 1 writes 1, and code 2 writes 0.
- R11: Code 3 in the retry, more-data, protected or EOSP code leaves that bit unchanged when the field is unprotected. In that case cfgError also rises one cycle after the start-of-frame handshake, and it stays high until reset. For EOSP this only applies when qosPresent is high.
- R12: The setup word and the side inputs are sampled on the accepted start-of-frame byte. Changes to them later in the frame have no effect on that frame.
- R13: The byte index moves forward only on a handshake (inValid and outReady both high). While outReady is low, the byte in flight is shown rewritten and is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupWord | input | 64 | Per-frame protect bits and settings |
| cryptoOn | input | 1 | Frame uses encryption (protected code 2) |
| retryBit | input | 1 | Retry bitmap bit for this MPDU (retry code 2) |
| mpduSeq | input | 12 | Sequence number from MPDU start |
| durVal | input | 16 | Duration replacement value |
| qosPresent | input | 1 | Header carries QoS control at bytes 24..25 |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Input byte is first of frame |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 8 | Output byte, rewritten where allowed |
| outSof | output | 1 | Output byte is first of frame |
| cfgError | output | 1 | Sticky flag for an illegal setting code |

## Verification
All field rewrites are combinational on the byte in flight. The bench therefore drives each byte just after a falling edge and compares outData in that same cycle, before the rising edge that completes the handshake. The configuration captured on the first byte applies from byte 1 onward. The illegal-code flag is registered, so the bench checks it one cycle after the start-of-frame handshake. During stalled beats, the byte index must not move, so the bench compares the held byte against the same expected value on every beat until outReady returns.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  localparam int IDX_W     = 5;
  localparam int FC_BYTE   = 1;
  localparam int DUR_BYTE  = 2;
  localparam int SEQ_BYTE  = 22;
  localparam int QOS_BYTE  = 24;

  typedef struct packed {
    logic fcHi;
    logic durLo;
    logic durHi;
    logic seqLo;
    logic seqHi;
    logic qosLo;
    logic qosHi;
  } mhrStrobe_t;

  typedef struct packed {
    logic        cryptoOn;
    logic        retryBit;
    logic [11:0] mpduSeq;
    logic [15:0] durVal;
    logic        qosPresent;
  } mhrSide_t;
endpackage

// File: rtl/mhr_ctrl.sv
module mhr_ctrl
  import mhr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        outReady,
  input  logic [63:0] setupWord,
  input  mhrSide_t    sideIn,
  output mhrStrobe_t  strobe,
  output logic [63:0] cfgLat,
  output mhrSide_t    sideLat,
  output logic        cfgError
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] curIdx;
  logic             fire;
  logic             illegal;

  assign fire   = inValid & outReady;
  assign curIdx = inSof ? '0 : cnt;

  always_comb begin
    illegal = 1'b0;
    if (!setupWord[3] && setupWord[21:20] == 2'd3) illegal = 1'b1;
    if (!setupWord[5] && setupWord[24:23] == 2'd3) illegal = 1'b1;
    if (!setupWord[6] && setupWord[26:25] == 2'd3) illegal = 1'b1;
    if (sideIn.qosPresent && !setupWord[11] && setupWord[33:32] == 2'd3) illegal = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      cfgLat   <= '1;
      sideLat  <= '0;
      cfgError <= 1'b0;
    end else if (fire) begin
      if (inSof) begin
        cnt      <= IDX_W'(1);
        cfgLat   <= setupWord;
        sideLat  <= sideIn;
        cfgError <= cfgError | illegal;
      end else if (cnt != IDX_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.fcHi  = inValid && curIdx == IDX_W'(FC_BYTE);
    strobe.durLo = inValid && curIdx == IDX_W'(DUR_BYTE);
    strobe.durHi = inValid && curIdx == IDX_W'(DUR_BYTE + 1);
    strobe.seqLo = inValid && curIdx == IDX_W'(SEQ_BYTE);
    strobe.seqHi = inValid && curIdx == IDX_W'(SEQ_BYTE + 1);
    strobe.qosLo = inValid && sideLat.qosPresent && curIdx == IDX_W'(QOS_BYTE);
    strobe.qosHi = inValid && sideLat.qosPresent && curIdx == IDX_W'(QOS_BYTE + 1);
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError); // R11
  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R1
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !outReady && !inSof) |=> $stable(cnt)); // R13
  AST_SOF_NO_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    inSof |-> strobe == '0); // R1
endmodule

// File: rtl/mhr_datapath.sv
module mhr_datapath
  import mhr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mhrStrobe_t  strobe,
  input  logic [63:0] cfg,
  input  mhrSide_t    side,
  input  logic [7:0]  inData,
  output logic [7:0]  outData
);
  function automatic logic pickCode(input logic [1:0] code, input logic alt, input logic orig);
    case (code)
      2'd0:    return 1'b0;
      2'd1:    return 1'b1;
      2'd2:    return alt;
      default: return orig;
    endcase
  endfunction

  logic [7:0]  fcVal;
  logic [7:0]  fcOut;
  logic [15:0] seqVal;
  logic [7:0]  qosLoOut;
  logic [7:0]  qosHiOut;
  logic        unusedBits;

  assign unusedBits = ^{cfg[14], cfg[16], cfg[46:45]};

  always_comb begin
    fcVal[0] = cfg[17];
    fcVal[1] = cfg[18];
    fcVal[2] = cfg[19];
    fcVal[3] = pickCode(cfg[21:20], side.retryBit, inData[3]);
    fcVal[4] = cfg[22];
    fcVal[5] = pickCode(cfg[24:23], 1'b0, inData[5]);
    fcVal[6] = pickCode(cfg[26:25], side.cryptoOn, inData[6]);
    fcVal[7] = cfg[27];
  end

  for (genvar b = 0; b < 8; b++) begin : g_fcBit
    assign fcOut[b] = cfg[b] ? inData[b] : fcVal[b];
  end

  assign seqVal = cfg[47] ? cfg[63:48] : {side.mpduSeq, 4'h0};

  always_comb begin
    qosLoOut      = inData;
    if (!cfg[10]) qosLoOut[3:0] = cfg[31:28];
    if (!cfg[11]) qosLoOut[4]   = pickCode(cfg[33:32], 1'b0, inData[4]);
    if (!cfg[12]) qosLoOut[6:5] = cfg[35:34];
    if (!cfg[13]) qosLoOut[7]   = cfg[36];
    qosHiOut = cfg[15] ? inData : cfg[44:37];
  end

  always_comb begin
    outData = inData;
    if (strobe.fcHi)            outData = fcOut;
    if (strobe.durLo && !cfg[8]) outData = side.durVal[7:0];
    if (strobe.durHi && !cfg[8]) outData = side.durVal[15:8];
    if (strobe.seqLo && !cfg[9]) outData = seqVal[7:0];
    if (strobe.seqHi && !cfg[9]) outData = seqVal[15:8];
    if (strobe.qosLo)           outData = qosLoOut;
    if (strobe.qosHi)           outData = qosHiOut;
  end

  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |-> outData == inData); // R1
  AST_FC_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fcHi && cfg[7:0] == 8'hFF) |-> outData == inData); // R2
  AST_DUR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.durLo && !cfg[8]) |-> outData == side.durVal[7:0]); // R7
  AST_SEQ_HIGH_PROT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.seqHi && cfg[9]) |-> outData == inData); // R8
endmodule

// File: rtl/mac_hdr_rewriter.sv
module mac_hdr_rewriter
  import mhr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] setupWord,
  input  logic        cryptoOn,
  input  logic        retryBit,
  input  logic [11:0] mpduSeq,
  input  logic [15:0] durVal,
  input  logic        qosPresent,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inSof,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outData,
  output logic        outSof,
  output logic        cfgError
);
  mhrStrobe_t  strobe;
  mhrSide_t    sideIn;
  mhrSide_t    sideLat;
  logic [63:0] cfgLat;

  assign sideIn   = '{cryptoOn: cryptoOn, retryBit: retryBit, mpduSeq: mpduSeq,
                      durVal: durVal, qosPresent: qosPresent};
  assign outValid = inValid;
  assign inReady  = outReady;
  assign outSof   = inSof;

  mhr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .outReady(outReady),
    .setupWord(setupWord), .sideIn(sideIn), .strobe(strobe), .cfgLat(cfgLat),
    .sideLat(sideLat), .cfgError(cfgError)
  );

  mhr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfgLat), .side(sideLat),
    .inData(inData), .outData(outData)
  );
endmodule

// File: tb/mac_hdr_rewriter_bench.sv
module mac_hdr_rewriter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 30;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] setupWord;
  logic        cryptoOn, retryBit, qosPresent;
  logic [11:0] mpduSeq;
  logic [15:0] durVal;
  logic        inValid, inReady, inSof, outValid, outReady, outSof, cfgError;
  logic [7:0]  inData, outData;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hdr_rewriter u_mac_hdr_rewriter (
    .clk(clk), .rstN(rstN), .setupWord(setupWord), .cryptoOn(cryptoOn),
    .retryBit(retryBit), .mpduSeq(mpduSeq), .durVal(durVal), .qosPresent(qosPresent),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSof(outSof),
    .cfgError(cfgError)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic code3(input logic [1:0] c, input logic alt, input logic orig);
    return c == 2'd0 ? 1'b0 : c == 2'd1 ? 1'b1 : c == 2'd2 ? alt : orig;
  endfunction

  function automatic logic [7:0] model(input int idx, input logic [7:0] b, input logic [63:0] s,
      input logic cr, input logic rb, input logic [11:0] sq, input logic [15:0] du, input logic qp);
    logic [7:0] r;
    logic [15:0] sc;
    r  = b;
    sc = s[47] ? s[63:48] : {sq, 4'h0};
    case (idx)
      1: begin
        if (!s[0]) r[0] = s[17];
        if (!s[1]) r[1] = s[18];
        if (!s[2]) r[2] = s[19];
        if (!s[3]) r[3] = code3(s[21:20], rb, b[3]);
        if (!s[4]) r[4] = s[22];
        if (!s[5]) r[5] = code3(s[24:23], 1'b0, b[5]);
        if (!s[6]) r[6] = code3(s[26:25], cr, b[6]);
        if (!s[7]) r[7] = s[27];
      end
      2:  if (!s[8]) r = du[7:0];
      3:  if (!s[8]) r = du[15:8];
      22: if (!s[9]) r = sc[7:0];
      23: if (!s[9]) r = sc[15:8];
      24: if (qp) begin
        if (!s[10]) r[3:0] = s[31:28];
        if (!s[11]) r[4]   = code3(s[33:32], 1'b0, b[4]);
        if (!s[12]) r[6:5] = s[35:34];
        if (!s[13]) r[7]   = s[36];
      end
      25: if (qp && !s[15]) r = s[44:37];
      default: ;
    endcase
    return r;
  endfunction

  // Sends one frame; scramble changes inputs after byte 0, stall drops outReady on some beats.
  task automatic runFrame(input string req, input logic [63:0] s, input logic [7:0] seed,
                          input bit scramble, input bit stall);
    logic [63:0] s0 = s;
    logic cr0 = cryptoOn, rb0 = retryBit, qp0 = qosPresent;
    logic [11:0] sq0 = mpduSeq;
    logic [15:0] du0 = durVal;
    int k = 0;
    setupWord = s;
    for (int i = 0; i < FRAME_LEN; i++) begin
      logic [7:0] d;
      bit done;
      d = 8'(i * 37) ^ seed;
      done = 0;
      while (!done) begin
        @(negedge clk);
        inValid  = 1'b1;
        inData   = d;
        inSof    = (i == 0);
        outReady = stall ? (k % 3 != 1) : 1'b1;
        k++;
        #1;
        check({req, " byte"}, outData, model(i, d, s0, cr0, rb0, sq0, du0, qp0));
        check("R1 stream", {outValid, inReady, outSof}, {1'b1, outReady, inSof});
        done = outReady;
        @(posedge clk);
        if (done && i == 0 && scramble) begin
          #1;
          setupWord  = ~s0;
          cryptoOn   = ~cr0; retryBit = ~rb0; qosPresent = ~qp0;
          mpduSeq    = ~sq0; durVal   = ~du0;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; outReady = 1'b1;
    setupWord = s0; cryptoOn = cr0; retryBit = rb0; qosPresent = qp0;
    mpduSeq = sq0; durVal = du0;
  endtask

  task automatic resetDut();
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inData = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R11 reset error flag", cfgError, 1'b0);
    check("R1 reset outValid", outValid, 1'b0);
  endtask

  task automatic t_protected();
    // R2: all protect bits set, settings all ones: frame unchanged
    runFrame("R2 protected", {16'hFFFF, 1'b1, 15'h7FFF, 15'h7FFF, 17'h1FFFF}, 8'h5A, 0, 0);
  endtask

  task automatic t_fcFlags();
    // R3 single-bit flags set to 1/0 patterns, retry code 1 (R4)
    runFrame("R3 fc flags a", 64'h0000_0000_084D_0000 | (64'd1 << 20), 8'h00, 0, 0);
    runFrame("R3 fc flags b", 64'h0000_0000_0000_0000, 8'hFF, 0, 0);
  endtask

  task automatic t_retry();
    retryBit = 1'b1;
    runFrame("R4 retry code2 bit1", 64'd2 << 20, 8'h00, 0, 0);
    retryBit = 1'b0;
    runFrame("R4 retry code2 bit0", 64'd2 << 20, 8'hFF, 0, 0);
    runFrame("R4 retry code0", 64'd0, 8'hFF, 0, 0);
  endtask

  task automatic t_moreData();
    runFrame("R5 moredata code1", 64'd1 << 23, 8'h00, 0, 0);
    runFrame("R5 moredata code2", 64'd2 << 23, 8'hFF, 0, 0);
  endtask

  task automatic t_prot();
    cryptoOn = 1'b1;
    runFrame("R6 prot code2 crypto", 64'd2 << 25, 8'h00, 0, 0);
    cryptoOn = 1'b0;
    runFrame("R6 prot code2 clear", 64'd2 << 25, 8'hFF, 0, 0);
    runFrame("R6 prot code1", 64'd1 << 25, 8'h00, 0, 0);
  endtask

  task automatic t_duration();
    durVal = 16'hBEEF;
    runFrame("R7 duration", 64'h0000_0000_0000_FEFF, 8'h11, 0, 0);
  endtask

  task automatic t_seq();
    mpduSeq = 12'hA5C;
    runFrame("R8 seq from mpdu", 64'h0000_0000_0000_FDFF, 8'h22, 0, 0);
    runFrame("R8 seq from setup", 64'h7E39_8000_0000_FDFF, 8'h22, 0, 0);
  endtask

  task automatic t_qos();
    qosPresent = 1'b1;
    runFrame("R9 qos fields", 64'h0000_1ACD_9000_80FF, 8'h3C, 0, 0);
    runFrame("R10 eosp code1", 64'h0000_0001_0000_80FF, 8'h00, 0, 0);
    runFrame("R10 eosp code2", 64'h0000_0002_0000_80FF, 8'hFF, 0, 0);
    qosPresent = 1'b0;
    runFrame("R9 qos absent", 64'h0000_1ACD_9000_0000, 8'h3C, 0, 0);
  endtask

  task automatic t_latch();
    qosPresent = 1'b1; durVal = 16'h1234; mpduSeq = 12'h321; cryptoOn = 1'b1;
    runFrame("R12 latch on sof", 64'h0123_4567_0AB3_0000, 8'h77, 1, 0);
  endtask

  task automatic t_stall();
    qosPresent = 1'b1; durVal = 16'hC0DE;
    runFrame("R13 backpressure", 64'h89AB_CDEF_1234_0000, 8'h99, 0, 1);
  endtask

  task automatic t_illegal();
    qosPresent = 1'b1;
    runFrame("R11 code3 keeps bits", 64'h0000_0003_0000_0000 | (64'd3 << 20) | (64'd3 << 23) | (64'd3 << 25),
             8'hFF, 0, 0);
    #1;
    check("R11 error raised", cfgError, 1'b1);
    runFrame("R11 legal after error", 64'd0, 8'h00, 0, 0);
    #1;
    check("R11 error sticky", cfgError, 1'b1);
    resetDut();
    #1;
    check("R11 error cleared by reset", cfgError, 1'b0);
  endtask

  initial begin
    setupWord = '1; cryptoOn = 0; retryBit = 0; qosPresent = 0; mpduSeq = '0; durVal = '0;
    resetDut();
    t_reset();
    t_protected();
    t_fcFlags();
    t_retry();
    t_moreData();
    t_prot();
    t_duration();
    t_seq();
    t_qos();
    t_latch();
    t_stall();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule